// File: doc/BRIEF.md
# Set-Associative Replacement Selector with Lock Bits and Flush Assist

This block holds the replacement bookkeeping for an 8-way, 128-set cache. For every set it stores one valid bit and one lock bit per way, plus a 7-bit binary-tree pseudo-LRU word. For the set on `set_idx` it shows, without a clock, the way that a miss fill would evict (`victim_way`). It also raises `no_victim` when every way of that set is locked. The cache controller reports hits, fills, single-way invalidations and lock requests. The block updates its state on the next rising edge.

Victim choice normally takes the lowest-numbered way that is both invalid and unlocked. Only when no such way exists does it walk the pseudo-LRU tree. The walk steers around locked subtrees. With `flush_assist` high, invalid ways get no preference and the tree walk alone decides. Eight distinct fills to one set then visit every way once, which makes a cache flush routine short and predictable. Two self-clearing flash controls are provided. One wipes every lock bit and the other invalidates every entry, each in a single cycle. A warm reset clears the valid and pseudo-LRU state but keeps the locks. Only the power-up reset clears the locks.

Top module: `plru_victim_sel`

## Requirements
- R1: After power-up reset (`por_n` low, then two further clock edges for the internal release), every valid bit, lock bit and tree bit reads 0, both pending flags read 0, `victim_way` is 0 and `no_victim` is 0. A power-up reset also clears locks that were set before it.
- R2: `warm_rst_n` is sampled synchronously. At a rising edge where it is low, every valid bit and every tree bit of every set become 0, and every lock bit keeps its value.
- R3: With `flush_assist` low, if the addressed set has any way that is both invalid and unlocked, `victim_way` is the lowest-numbered such way.
- R4: Otherwise `victim_way` comes from the tree walk. Node 0 is the root, and node n has children 2n+1 and 2n+2. Tree bit i of `plru_bits` belongs to node i. A bit of 0 steers toward the lower-numbered ways, and leaf node k stands for way k-7.
- R5: A hit updates the addressed set's tree on the path to `acc_way`, and a performed fill updates it on the path to the victim. Every node on the path is set to point away from the accessed way (1 if that way lies in the node's lower half, otherwise 0). Nodes off the path are unchanged.
- R6: With `flush_assist` high, invalid ways are ignored. Starting from an all-zero tree, eight fills to one set choose ways 0, 4, 2, 6, 1, 5, 3, 7 in that order, and the tree returns to all zero.
- R7: `victim_way` never names a locked way. When the steered child subtree has no unlocked way, the walk takes the other child.
- R8: `no_victim` is 1 exactly when all eight lock bits of the addressed set are 1. A `fill_req` in that state changes neither valid bits nor tree bits.
- R9: A performed fill sets the victim's valid bit. `inv_req` clears the valid bit of `acc_way`. `lock_req` sets the lock bit of `acc_way`. All of these act on the set on `set_idx`. When several strobes are high together, fill takes precedence over hit, and hit over invalidate.
- R10: A pulse on `lock_fclr_wr` makes `lock_fclr_pend` read 1 for the following cycle only. The rising edge that ends that cycle clears every lock bit of every set, and this takes priority over `lock_req`.
- R11: A pulse on `inv_fclr_wr` makes `inv_fclr_pend` read 1 for the following cycle only. The rising edge that ends that cycle clears every valid bit of every set, and this takes priority over fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, asynchronous assert, active low |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low |
| set_idx | input | 7 | Addressed set |
| acc_way | input | 3 | Way for hit, invalidate and lock |
| hit_req | input | 1 | Hit to `acc_way` |
| fill_req | input | 1 | Miss fill into the current victim |
| inv_req | input | 1 | Invalidate `acc_way` |
| lock_req | input | 1 | Lock `acc_way` |
| flush_assist | input | 1 | Victim from tree walk only |
| lock_fclr_wr | input | 1 | Write of the lock flash-clear control |
| inv_fclr_wr | input | 1 | Write of the valid flash-invalidate control |
| victim_way | output | 3 | Way a fill would use |
| no_victim | output | 1 | All ways of the set locked |
| valid_vec | output | 8 | Valid bits of the addressed set |
| lock_vec | output | 8 | Lock bits of the addressed set |
| plru_bits | output | 7 | Tree bits of the addressed set |
| lock_fclr_pend | output | 1 | Lock flash-clear control bit |
| inv_fclr_pend | output | 1 | Flash-invalidate control bit |

## Verification
The bench first fills an empty set with `flush_assist` low and then high. A selector that kept the invalid-first preference under flush assist would repeat way 0 or diverge from the 0,4,2,6,1,5,3,7 order. It then locks ways of a fresh set one at a time. A walk that ignored locks would evict way 0 or 1, and a missing all-locked detection would let a fill mark a way valid. Warm reset and the two flash controls are each followed cycle by cycle. A lock array wired to the warm reset would lose its locks, and a sticky control bit would stay high a second cycle.

// File: rtl/plru_pkg.sv
package plru_pkg;
  // Access that updates the addressed set this cycle, in precedence order.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_FILL = 2'd1,
    ACC_HIT  = 2'd2,
    ACC_INV  = 2'd3
  } acc_e;
endpackage

// File: rtl/plru_tree_pick.sv
// Tree walk that follows the pseudo-LRU bits but turns away from
// subtrees whose ways are all locked.
module plru_tree_pick #(
  parameter int WAYS = 8,
  localparam int WB = $clog2(WAYS),
  localparam int NODES = 2 * WAYS - 1,
  localparam int NB = $clog2(NODES)
) (
  input  logic [WAYS-2:0] plru,
  input  logic [WAYS-1:0] lock,
  output logic [WB-1:0]   way
);
  logic [NODES-1:0] avail;
  logic [NB-1:0]    node;
  logic [NB-1:0]    lchild;
  logic             go;

  // Subtree has at least one unlocked leaf.
  always_comb begin
    avail = '0;
    for (int w = 0; w < WAYS; w++) avail[WAYS-1+w] = ~lock[w];
    for (int n = WAYS - 2; n >= 0; n--) avail[n] = avail[2*n+1] | avail[2*n+2];
  end

  always_comb begin
    node   = '0;
    lchild = '0;
    go     = 1'b0;
    for (int l = 0; l < WB; l++) begin
      lchild = (node << 1) + NB'(1);
      go     = plru[node[WB-1:0]];
      if (!go && !avail[lchild])             go = 1'b1;
      else if (go && !avail[lchild + NB'(1)]) go = 1'b0;
      node = lchild + NB'(go);
    end
    way = WB'(node - NB'(WAYS - 1));
  end
endmodule

// File: rtl/plru_tree_upd.sv
// New tree word after an access: path nodes point away from the way.
module plru_tree_upd #(
  parameter int WAYS = 8,
  localparam int WB = $clog2(WAYS),
  localparam int NB = $clog2(2 * WAYS - 1)
) (
  input  logic [WAYS-2:0] plru_in,
  input  logic [WB-1:0]   way,
  output logic [WAYS-2:0] plru_out
);
  logic [NB-1:0] node;
  logic          dir;

  always_comb begin
    plru_out = plru_in;
    node     = '0;
    dir      = 1'b0;
    for (int l = 0; l < WB; l++) begin
      dir = way[WB-1-l];
      plru_out[node[WB-1:0]] = ~dir;
      node = (node << 1) + NB'(1) + NB'(dir);
    end
  end
endmodule

// File: rtl/plru_flash_ctl.sv
// Self-clearing control bits: a write sets the bit for one cycle only.
module plru_flash_ctl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wr,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_d;

  always_comb begin
    pend_d = wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_d;
  end
endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel
  import plru_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 8,
  localparam int SB = $clog2(SETS),
  localparam int WB = $clog2(WAYS),
  localparam int PB = WAYS - 1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          warm_rst_n,
  input  logic [SB-1:0] set_idx,
  input  logic [WB-1:0] acc_way,
  input  logic          hit_req,
  input  logic          fill_req,
  input  logic          inv_req,
  input  logic          lock_req,
  input  logic          flush_assist,
  input  logic          lock_fclr_wr,
  input  logic          inv_fclr_wr,
  output logic [WB-1:0] victim_way,
  output logic          no_victim,
  output logic [WAYS-1:0] valid_vec,
  output logic [WAYS-1:0] lock_vec,
  output logic [PB-1:0] plru_bits,
  output logic          lock_fclr_pend,
  output logic          inv_fclr_pend
);
  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rs_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  // Flash controls.
  logic [1:0] fpend;
  plru_flash_ctl #(.N(2)) u_flash (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   ({inv_fclr_wr, lock_fclr_wr}),
    .pend (fpend)
  );
  assign lock_fclr_pend = fpend[0];
  assign inv_fclr_pend  = fpend[1];

  // State arrays.
  logic [WAYS-1:0] vld_q  [SETS];
  logic [WAYS-1:0] vld_d  [SETS];
  logic [WAYS-1:0] lck_q  [SETS];
  logic [WAYS-1:0] lck_d  [SETS];
  logic [PB-1:0]   plru_q [SETS];
  logic [PB-1:0]   plru_d [SETS];

  assign valid_vec = vld_q[set_idx];
  assign lock_vec  = lck_q[set_idx];
  assign plru_bits = plru_q[set_idx];

  // Victim choice.
  logic [WAYS-1:0] free_ways;
  logic [WB-1:0]   low_free;
  logic [WB-1:0]   tree_way;

  plru_tree_pick #(.WAYS(WAYS)) u_pick (
    .plru(plru_bits),
    .lock(lock_vec),
    .way (tree_way)
  );

  assign free_ways = ~valid_vec & ~lock_vec;
  assign no_victim = &lock_vec;

  always_comb begin
    low_free = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (free_ways[w]) low_free = WB'(w);
    end
  end

  always_comb begin
    if (!flush_assist && |free_ways) victim_way = low_free;
    else                             victim_way = tree_way;
  end

  // Access decode and tree update.
  acc_e          acc;
  logic [WB-1:0] upd_way;
  logic [PB-1:0] plru_upd;

  always_comb begin
    if (fill_req)     acc = no_victim ? ACC_NONE : ACC_FILL;
    else if (hit_req) acc = ACC_HIT;
    else if (inv_req) acc = ACC_INV;
    else              acc = ACC_NONE;
  end

  assign upd_way = (acc == ACC_FILL) ? victim_way : acc_way;

  plru_tree_upd #(.WAYS(WAYS)) u_upd (
    .plru_in (plru_bits),
    .way     (upd_way),
    .plru_out(plru_upd)
  );

  // Next state.
  logic vp_en;
  logic lk_en;

  always_comb begin
    vld_d  = vld_q;
    plru_d = plru_q;
    lck_d  = lck_q;
    unique case (acc)
      ACC_FILL: begin
        vld_d[set_idx][victim_way] = 1'b1;
        plru_d[set_idx]            = plru_upd;
      end
      ACC_HIT:  plru_d[set_idx] = plru_upd;
      ACC_INV:  vld_d[set_idx][acc_way] = 1'b0;
      default:  ;
    endcase
    if (lock_req) lck_d[set_idx][acc_way] = 1'b1;
    if (!warm_rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_d[s]  = '0;
        plru_d[s] = '0;
      end
    end
    if (inv_fclr_pend) begin
      for (int s = 0; s < SETS; s++) vld_d[s] = '0;
    end
    if (lock_fclr_pend) begin
      for (int s = 0; s < SETS; s++) lck_d[s] = '0;
    end
  end

  assign vp_en = (acc != ACC_NONE) || !warm_rst_n || inv_fclr_pend;
  assign lk_en = lock_req || lock_fclr_pend;

  // Registers: valid and tree (power-up, warm, flash invalidate).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
    end else if (vp_en) begin
      vld_q  <= vld_d;
      plru_q <= plru_d;
    end
  end

  // Registers: locks (power-up reset only).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) lck_q[s] <= '0;
    end else if (lk_en) begin
      lck_q <= lck_d;
    end
  end
endmodule

// File: rtl/plru_victim_sel_chk.sv
module plru_victim_sel_chk #(
  parameter int SETS = 128,
  parameter int WAYS = 8,
  localparam int SB = $clog2(SETS),
  localparam int WB = $clog2(WAYS),
  localparam int PB = WAYS - 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            warm_rst_n,
  input logic [SB-1:0]   set_idx,
  input logic            fill_req,
  input logic            flush_assist,
  input logic            lock_fclr_wr,
  input logic            inv_fclr_wr,
  input logic [WB-1:0]   victim_way,
  input logic            no_victim,
  input logic [WAYS-1:0] valid_vec,
  input logic [WAYS-1:0] lock_vec,
  input logic [PB-1:0]   plru_bits,
  input logic            lock_fclr_pend,
  input logic            inv_fclr_pend
);
  assert_warm_keeps_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_rst_n |=> (valid_vec == '0 && plru_bits == '0));

  assert_invalid_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_assist && |(~valid_vec & ~lock_vec)) |->
      (!valid_vec[victim_way] && !lock_vec[victim_way]));

  assert_victim_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !no_victim |-> !lock_vec[victim_way]);

  assert_all_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&lock_vec) |-> no_victim);

  assert_fill_marks_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !no_victim && warm_rst_n && !inv_fclr_pend) |=>
      ((set_idx != $past(set_idx)) || valid_vec[$past(victim_way)]));

  assert_lock_ctl_selfclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_fclr_wr |=> !lock_fclr_pend);

  assert_lock_flash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fclr_pend |=> (lock_vec == '0));

  assert_inv_ctl_selfclr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_fclr_wr |=> !inv_fclr_pend);

  assert_inv_flash_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_fclr_pend |=> (valid_vec == '0));
endmodule

bind plru_victim_sel plru_victim_sel_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .warm_rst_n    (warm_rst_n),
  .set_idx       (set_idx),
  .fill_req      (fill_req),
  .flush_assist  (flush_assist),
  .lock_fclr_wr  (lock_fclr_wr),
  .inv_fclr_wr   (inv_fclr_wr),
  .victim_way    (victim_way),
  .no_victim     (no_victim),
  .valid_vec     (valid_vec),
  .lock_vec      (lock_vec),
  .plru_bits     (plru_bits),
  .lock_fclr_pend(lock_fclr_pend),
  .inv_fclr_pend (inv_fclr_pend)
);

// File: tb/tb_plru_victim_sel.sv
`timescale 1ns/1ps
module tb_plru_victim_sel;
  logic       clk;
  logic       por_n, warm_rst_n;
  logic [6:0] set_idx;
  logic [2:0] acc_way;
  logic       hit_req, fill_req, inv_req, lock_req, flush_assist;
  logic       lock_fclr_wr, inv_fclr_wr;
  logic [2:0] victim_way;
  logic       no_victim;
  logic [7:0] valid_vec, lock_vec;
  logic [6:0] plru_bits;
  logic       lock_fclr_pend, inv_fclr_pend;

  int n_chk = 0;
  int n_err = 0;

  plru_victim_sel dut (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .set_idx(set_idx), .acc_way(acc_way),
    .hit_req(hit_req), .fill_req(fill_req), .inv_req(inv_req),
    .lock_req(lock_req), .flush_assist(flush_assist),
    .lock_fclr_wr(lock_fclr_wr), .inv_fclr_wr(inv_fclr_wr),
    .victim_way(victim_way), .no_victim(no_victim),
    .valid_vec(valid_vec), .lock_vec(lock_vec), .plru_bits(plru_bits),
    .lock_fclr_pend(lock_fclr_pend), .inv_fclr_pend(inv_fclr_pend)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector: {req[3:0], op[2:0], set[6:0], way[2:0], fa, chk, exp[2:0]}
  // op: 0 none, 1 fill, 2 hit, 3 lock, 4 invalidate
  localparam int NV = 23;
  localparam logic [21:0] VEC [NV] = '{
    {4'd3, 3'd1, 7'd5, 3'd0, 1'b0, 1'b1, 3'd0},  // R3 empty set, lowest invalid
    {4'd3, 3'd1, 7'd5, 3'd0, 1'b0, 1'b1, 3'd1},
    {4'd3, 3'd1, 7'd5, 3'd0, 1'b0, 1'b1, 3'd2},
    {4'd3, 3'd1, 7'd5, 3'd0, 1'b0, 1'b1, 3'd3},
    {4'd3, 3'd1, 7'd5, 3'd0, 1'b0, 1'b1, 3'd4},
    {4'd3, 3'd1, 7'd5, 3'd0, 1'b0, 1'b1, 3'd5},
    {4'd3, 3'd1, 7'd5, 3'd0, 1'b0, 1'b1, 3'd6},
    {4'd3, 3'd1, 7'd5, 3'd0, 1'b0, 1'b1, 3'd7},
    {4'd4, 3'd0, 7'd5, 3'd0, 1'b0, 1'b1, 3'd0},  // R4 full set, tree all zero
    {4'd5, 3'd2, 7'd5, 3'd0, 1'b0, 1'b0, 3'd0},  // R5 hit way 0
    {4'd5, 3'd0, 7'd5, 3'd0, 1'b0, 1'b1, 3'd4},  // R5 tree points right
    {4'd9, 3'd4, 7'd5, 3'd6, 1'b0, 1'b0, 3'd0},  // R9 invalidate way 6
    {4'd9, 3'd0, 7'd5, 3'd0, 1'b0, 1'b1, 3'd6},  // R9 hole used first
    {4'd6, 3'd0, 7'd5, 3'd0, 1'b1, 1'b1, 3'd4},  // R6 hole ignored
    {4'd6, 3'd1, 7'd20, 3'd0, 1'b1, 1'b1, 3'd0}, // R6 flush order
    {4'd6, 3'd1, 7'd20, 3'd0, 1'b1, 1'b1, 3'd4},
    {4'd6, 3'd1, 7'd20, 3'd0, 1'b1, 1'b1, 3'd2},
    {4'd6, 3'd1, 7'd20, 3'd0, 1'b1, 1'b1, 3'd6},
    {4'd6, 3'd1, 7'd20, 3'd0, 1'b1, 1'b1, 3'd1},
    {4'd6, 3'd1, 7'd20, 3'd0, 1'b1, 1'b1, 3'd5},
    {4'd6, 3'd1, 7'd20, 3'd0, 1'b1, 1'b1, 3'd3},
    {4'd6, 3'd1, 7'd20, 3'd0, 1'b1, 1'b1, 3'd7},
    {4'd6, 3'd0, 7'd20, 3'd0, 1'b1, 1'b1, 3'd0}  // R6 wrap to way 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    hit_req = 0; fill_req = 0; inv_req = 0; lock_req = 0;
    lock_fclr_wr = 0; inv_fclr_wr = 0; warm_rst_n = 1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic do_op(input logic [2:0] op, input logic [6:0] s, input logic [2:0] w);
    set_idx = s; acc_way = w;
    case (op)
      3'd1: fill_req = 1;
      3'd2: hit_req  = 1;
      3'd3: lock_req = 1;
      3'd4: inv_req  = 1;
      default: ;
    endcase
    step();
  endtask

  task automatic por();
    @(negedge clk);
    por_n = 0;
    step();
    por_n = 1;
    step(); step(); step();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    por_n = 0; set_idx = 0; acc_way = 0; flush_assist = 0;
    idle();
    por();

    // R1 reset state
    set_idx = 0; #1;
    check("R1 valid", valid_vec, 8'h00);
    check("R1 lock", lock_vec, 8'h00);
    check("R1 plru", plru_bits, 7'h00);
    check("R1 pend", {lock_fclr_pend, inv_fclr_pend}, 2'b00);
    check("R1 victim", {no_victim, victim_way}, 4'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      flush_assist = VEC[i][4];
      set_idx = VEC[i][14:8];
      #1;
      if (VEC[i][3])
        check($sformatf("R%0d vec%0d", VEC[i][21:18], i), victim_way, VEC[i][2:0]);
      do_op(VEC[i][17:15], VEC[i][14:8], VEC[i][7:5]);
    end

    // R5 tree bits after hits
    flush_assist = 0;
    do_op(3'd2, 7'd30, 3'd5);
    check("R5 hit5", plru_bits, 7'b0000100);
    do_op(3'd2, 7'd30, 3'd2);
    check("R5 hit2", plru_bits, 7'b0010101);

    // R7 lock avoidance on set 9
    do_op(3'd3, 7'd9, 3'd0);
    check("R9 lock0", lock_vec, 8'h01);
    flush_assist = 0; #1;
    check("R7 normal", victim_way, 3'd1);
    flush_assist = 1; #1;
    check("R7 tree skip", victim_way, 3'd1);
    do_op(3'd3, 7'd9, 3'd1);
    check("R7 tree skip subtree", victim_way, 3'd2);
    for (int w = 2; w < 8; w++) do_op(3'd3, 7'd9, w[2:0]);
    check("R8 no_victim", no_victim, 1'b1);
    do_op(3'd1, 7'd9, 3'd0);
    check("R8 fill ignored valid", valid_vec, 8'h00);
    check("R8 fill ignored plru", plru_bits, 7'h00);

    // R10 lock flash clear
    lock_fclr_wr = 1; step();
    check("R10 pend set", lock_fclr_pend, 1'b1);
    check("R10 locks held", lock_vec, 8'hFF);
    step();
    check("R10 pend cleared", lock_fclr_pend, 1'b0);
    check("R10 locks cleared", lock_vec, 8'h00);
    check("R10 victim free", no_victim, 1'b0);

    // R2 warm reset keeps locks
    flush_assist = 0;
    do_op(3'd1, 7'd12, 3'd0);
    do_op(3'd3, 7'd12, 3'd3);
    check("R9 fill valid", valid_vec, 8'h01);
    warm_rst_n = 0; step();
    check("R2 valid", valid_vec, 8'h00);
    check("R2 plru", plru_bits, 7'h00);
    check("R2 lock kept", lock_vec, 8'h08);

    // R11 flash invalidate
    do_op(3'd1, 7'd40, 3'd0);
    do_op(3'd1, 7'd40, 3'd0);
    check("R9 two fills", valid_vec, 8'h03);
    inv_fclr_wr = 1; step();
    check("R11 pend set", inv_fclr_pend, 1'b1);
    check("R11 valid held", valid_vec, 8'h03);
    step();
    check("R11 pend cleared", inv_fclr_pend, 1'b0);
    check("R11 valid cleared", valid_vec, 8'h00);

    // R1 power-up clears locks
    por();
    set_idx = 7'd12; #1;
    check("R1 por clears lock", lock_vec, 8'h00);

    summary();
    $finish;
  end
endmodule